// File: doc/BRIEF.md
# System Control Registers: Interrupt Collector and General-Purpose Outputs

This block is the system control register file of a multi-function I/O companion device. A host reaches it through a bus that moves one byte per access. Eight sub-function interrupt lines feed a status register, and each line owns the bit of the same index. A mask register selects which status bits may raise the single host interrupt.

The block also drives sixteen general-purpose output pins. One byte-wide bank holds the output data and a second bank holds the output enables. A pin carries its data bit only while its enable bit is set. After any write to either bank, the block presents the new pin levels. It also gives a one-cycle change strobe on each pin whose level actually moved.

A routing byte, a 16-bit general-purpose enable word and a 32-bit control word are stored so that software can read them back. They drive nothing inside the block. Registers wider than a byte are reached one byte lane at a time.

Top module: `ioc_sysregs`

## Requirements
- R1: Each sub-function line i (0 storage, 1 card slot, 2 USB host, 3 serial, 4 display, 5 to 7 spare) sets status bit i on the clock edge where it is seen rising. It clears that bit on the edge where it is seen falling. The status register reads at offset 0x50.
- R2: `host_irq` is high exactly when status AND mask (the mask reads and writes at 0x52) has any bit set. It follows the registers in the same cycle that they change.
- R3: A bus write to offset 0x50 or 0x52 replaces the whole byte. When a line transitions in the same cycle as a status write, the line's new level wins for that bit. The written value is kept for all other bits.
- R4: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00. Writes to these two offsets change nothing and raise no error.
- R5: Output data occupies offsets 0x78, 0x79 and 0x7A, and output enable occupies 0x7C, 0x7D and 0x7E. In each bank the lowest offset holds bits 7:0. All three bytes of each bank read back as written.
- R6: `pin_lvl` equals data AND enable over bits 15:0. It changes in the cycle after a data or enable write is accepted, and at no other time.
- R7: After a data or enable write, `pin_evt` is high for one cycle on exactly the pins whose level differs from the previous `pin_lvl`. At all other times it is 0.
- R8: Multi-byte registers are little-endian byte lanes. The 16-bit enable word uses 0x60 and 0x61, and the 32-bit control word uses 0x9C through 0x9F. The routing byte is at 0x54. A byte write changes only its own lane.
- R9: A read of an unmapped offset returns 0. A write to an unmapped offset changes nothing. Either kind of unmapped access pulses `bus_err` for one cycle, in the cycle after the access.
- R10: After reset all registers, `pin_lvl`, `pin_evt`, `host_irq`, `bus_err` and `bus_rdata` are 0.
- R11: Read data appears on `bus_rdata` in the cycle after a read access. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, one byte per cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| bus_err | output | 1 | One-cycle strobe on an unmapped access |
| sub_irq | input | 8 | Sub-function interrupt lines, bit i is line i |
| host_irq | output | 1 | Combined masked interrupt |
| pin_lvl | output | 16 | Effective output pin levels |
| pin_evt | output | 16 | One-cycle per-pin change strobes |

## Verification
The interrupt path is driven with several line patterns:
- single lines and pairs of lines, which separate bit indexing from a simple OR of the lines;
- masks that cover none, one or all of the pending bits, which show whether the mask gates the output;
- a status write in the same cycle as a rising line, which shows which source wins for each bit.

The output pins are driven through a data and enable sequence:
- data written while the enable is clear, which must cause no event;
- a later enable write that produces exactly the deferred change;
- overlapping data rewrites, whose strobes must mark only the pins that moved.

Writes to the lanes of wide registers are interleaved, and unmapped holes between banks are accessed. Together these separate a correct lane decode from a shifted or over-wide one.

// File: rtl/ioc_sysregs_pkg.sv
package ioc_sysregs_pkg;

  localparam int NLINES     = 8;
  localparam int NPINS      = 16;
  localparam int GPIO_BYTES = 3;

  localparam logic [7:0] REV_ADDR   = 8'h08;
  localparam logic [7:0] STAT_ADDR  = 8'h50;
  localparam logic [7:0] MASK_ADDR  = 8'h52;
  localparam logic [7:0] ROUTE_ADDR = 8'h54;
  localparam logic [7:0] GPEN_BASE  = 8'h60;
  localparam logic [7:0] GDATA_BASE = 8'h78;
  localparam logic [7:0] GOE_BASE   = 8'h7C;
  localparam logic [7:0] WIDE_BASE  = 8'h9C;
  localparam logic [7:0] REV_VALUE  = 8'h03;

  typedef enum logic [3:0] {
    RG_NONE, RG_REV, RG_STAT, RG_MASK, RG_ROUTE,
    RG_GPEN, RG_GDATA, RG_GOE, RG_WIDE
  } reg_e;

  typedef struct packed {
    reg_e       id;
    logic [1:0] lane;
  } hit_t;

  // true when offset a lies in [base, base+n)
  function automatic logic in_span(input logic [7:0] a, input logic [7:0] base,
                                   input int n);
    logic [8:0] lim;
    lim = {1'b0, base} + 9'(n);
    in_span = ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim);
  endfunction

  function automatic hit_t decode_addr(input logic [7:0] a);
    hit_t h;
    h.id   = RG_NONE;
    h.lane = 2'd0;
    if (in_span(a, REV_ADDR, 2)) begin
      h.id = RG_REV;   h.lane = 2'(a - REV_ADDR);
    end else if (a == STAT_ADDR) begin
      h.id = RG_STAT;
    end else if (a == MASK_ADDR) begin
      h.id = RG_MASK;
    end else if (a == ROUTE_ADDR) begin
      h.id = RG_ROUTE;
    end else if (in_span(a, GPEN_BASE, 2)) begin
      h.id = RG_GPEN;  h.lane = 2'(a - GPEN_BASE);
    end else if (in_span(a, GDATA_BASE, GPIO_BYTES)) begin
      h.id = RG_GDATA; h.lane = 2'(a - GDATA_BASE);
    end else if (in_span(a, GOE_BASE, GPIO_BYTES)) begin
      h.id = RG_GOE;   h.lane = 2'(a - GOE_BASE);
    end else if (in_span(a, WIDE_BASE, 4)) begin
      h.id = RG_WIDE;  h.lane = 2'(a - WIDE_BASE);
    end
    return h;
  endfunction

  function automatic logic any_pending(input logic [NLINES-1:0] st,
                                       input logic [NLINES-1:0] mk);
    return |(st & mk);
  endfunction

  function automatic logic [NPINS-1:0] pin_effective(input logic [NPINS-1:0] d,
                                                     input logic [NPINS-1:0] e);
    return d & e;
  endfunction

endpackage

// File: rtl/ioc_lane_reg.sv
module ioc_lane_reg #(
  parameter int NBYTES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [1:0]            lane,
  input  logic [7:0]            wdata,
  output logic [NBYTES*8-1:0]   q
);
  localparam int W = NBYTES * 8;

  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (wr) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (lane == 2'(i)) q_r[i*8 +: 8] <= wdata;
      end
    end
  end

  assign q = q_r;

  // R8
  lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr) && $past(rst_n)) |-> $stable(q_r));
endmodule

// File: rtl/ioc_irq_collect.sv
module ioc_irq_collect
  import ioc_sysregs_pkg::*;
#(
  parameter int N = NLINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic         wr_stat,
  input  logic         wr_mask,
  input  logic [7:0]   wdata,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         host_irq
);
  logic [N-1:0] line_q, status_q, mask_q, flip;

  assign flip = lines ^ line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= lines;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       status_q[i] <= 1'b0;
      else if (flip[i]) status_q[i] <= lines[i];
      else if (wr_stat) status_q[i] <= wdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata[N-1:0];
  end

  assign host_irq = any_pending(status_q, mask_q);
  assign status_o = status_q;
  assign mask_o   = mask_q;

  // R1
  line_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((status_q ^ $past(lines)) & $past(flip)) == '0));
  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !host_irq);
  // R3
  stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_stat)) |->
      (((status_q ^ $past(wdata[N-1:0])) & ~$past(flip)) == '0));
endmodule

// File: rtl/ioc_gpio_out.sv
module ioc_gpio_out
  import ioc_sysregs_pkg::*;
#(
  parameter int NP = NPINS,
  parameter int NB = GPIO_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_data,
  input  logic            wr_oe,
  input  logic [1:0]      lane,
  input  logic [7:0]      wdata,
  output logic [NB*8-1:0] data_o,
  output logic [NB*8-1:0] oe_o,
  output logic [NP-1:0]   pin_lvl,
  output logic [NP-1:0]   pin_evt
);
  localparam int W = NB * 8;

  logic [W-1:0]  data_q, oe_q, d_nxt, e_nxt;
  logic [NP-1:0] lvl_q, evt_q, eff_nxt;
  logic          wr_any;

  assign wr_any = wr_data | wr_oe;

  always_comb begin
    d_nxt = data_q;
    e_nxt = oe_q;
    for (int i = 0; i < NB; i++) begin
      if (wr_data && lane == 2'(i)) d_nxt[i*8 +: 8] = wdata;
      if (wr_oe   && lane == 2'(i)) e_nxt[i*8 +: 8] = wdata;
    end
    eff_nxt = pin_effective(d_nxt[NP-1:0], e_nxt[NP-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= '0;
      lvl_q  <= '0;
      evt_q  <= '0;
    end else begin
      data_q <= d_nxt;
      oe_q   <= e_nxt;
      if (wr_any) begin
        evt_q <= lvl_q ^ eff_nxt;
        lvl_q <= eff_nxt;
      end else begin
        evt_q <= '0;
      end
    end
  end

  assign data_o  = data_q;
  assign oe_o    = oe_q;
  assign pin_lvl = lvl_q;
  assign pin_evt = evt_q;

  // R6
  lvl_within_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q & ~oe_q[NP-1:0]) == '0);
  // R6
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_any)) |-> $stable(lvl_q));
  // R7
  evt_only_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_any)) |-> (evt_q == '0));
  // R7
  evt_matches_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_any)) |-> (evt_q == ($past(lvl_q) ^ lvl_q)));
endmodule

// File: rtl/ioc_sysregs.sv
module ioc_sysregs
  import ioc_sysregs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_err,
  input  logic [NLINES-1:0] sub_irq,
  output logic              host_irq,
  output logic [NPINS-1:0]  pin_lvl,
  output logic [NPINS-1:0]  pin_evt
);
  localparam int GW = GPIO_BYTES * 8;

  hit_t              hit;
  logic              wr, rd;
  logic              wr_stat, wr_mask, wr_route, wr_gpen, wr_wide, wr_gdata, wr_goe;
  logic [NLINES-1:0] status, mask;
  logic [7:0]        route;
  logic [15:0]       gpen;
  logic [31:0]       wide;
  logic [GW-1:0]     gdata, goe;
  logic [7:0]        rd_mux;
  logic [7:0]        rdata_q;
  logic              err_q;

  assign hit = decode_addr(bus_addr);
  assign wr  = bus_sel & bus_we;
  assign rd  = bus_sel & ~bus_we;

  assign wr_stat  = wr && hit.id == RG_STAT;
  assign wr_mask  = wr && hit.id == RG_MASK;
  assign wr_route = wr && hit.id == RG_ROUTE;
  assign wr_gpen  = wr && hit.id == RG_GPEN;
  assign wr_wide  = wr && hit.id == RG_WIDE;
  assign wr_gdata = wr && hit.id == RG_GDATA;
  assign wr_goe   = wr && hit.id == RG_GOE;

  ioc_irq_collect #(.N(NLINES)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (sub_irq),
    .wr_stat  (wr_stat),
    .wr_mask  (wr_mask),
    .wdata    (bus_wdata),
    .status_o (status),
    .mask_o   (mask),
    .host_irq (host_irq)
  );

  ioc_gpio_out #(.NP(NPINS), .NB(GPIO_BYTES)) u_gpio (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data (wr_gdata),
    .wr_oe   (wr_goe),
    .lane    (hit.lane),
    .wdata   (bus_wdata),
    .data_o  (gdata),
    .oe_o    (goe),
    .pin_lvl (pin_lvl),
    .pin_evt (pin_evt)
  );

  ioc_lane_reg #(.NBYTES(1)) u_route (
    .clk (clk), .rst_n (rst_n), .wr (wr_route), .lane (hit.lane),
    .wdata (bus_wdata), .q (route)
  );

  ioc_lane_reg #(.NBYTES(2)) u_gpen (
    .clk (clk), .rst_n (rst_n), .wr (wr_gpen), .lane (hit.lane),
    .wdata (bus_wdata), .q (gpen)
  );

  ioc_lane_reg #(.NBYTES(4)) u_wide (
    .clk (clk), .rst_n (rst_n), .wr (wr_wide), .lane (hit.lane),
    .wdata (bus_wdata), .q (wide)
  );

  always_comb begin
    rd_mux = 8'h00;
    case (hit.id)
      RG_REV:   rd_mux = (hit.lane == 2'd0) ? REV_VALUE : 8'h00;
      RG_STAT:  rd_mux = 8'(status);
      RG_MASK:  rd_mux = 8'(mask);
      RG_ROUTE: rd_mux = route;
      RG_GPEN:  rd_mux = gpen[hit.lane[0]*8 +: 8];
      RG_GDATA: rd_mux = gdata[hit.lane*8 +: 8];
      RG_GOE:   rd_mux = goe[hit.lane*8 +: 8];
      RG_WIDE:  rd_mux = wide[hit.lane*8 +: 8];
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 8'h00;
      err_q   <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_mux;
      err_q <= bus_sel && (hit.id == RG_NONE);
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  // R9
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(rst_n) && $past(bus_sel)));
  // R9
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_sel)) |-> !bus_err);
  // R4
  rev_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rd) && $past(bus_addr) == REV_ADDR) |-> (bus_rdata == 8'h03));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd)) |-> $stable(bus_rdata));
endmodule

// File: tb/ioc_sysregs_bench.sv
module ioc_sysregs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        bus_err;
  logic [7:0]  sub_irq = 8'h00;
  logic        host_irq;
  logic [15:0] pin_lvl;
  logic [15:0] pin_evt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic rd_q = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  ioc_sysregs u_ioc_sysregs (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .bus_err (bus_err), .sub_irq (sub_irq), .host_irq (host_irq),
    .pin_lvl (pin_lvl), .pin_evt (pin_evt)
  );

  always @(posedge clk) rd_q <= bus_sel && !bus_we;

  // monitor: compare each returned read byte with the queued expectation
  always @(negedge clk) begin
    if (rd_q) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R11 unexpected read data: actual=%02h expected=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s read: actual=%02h expected=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%04h expected=%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R10 reset state
    chk("R10 host_irq", {15'd0, host_irq}, 16'h0);
    chk("R10 pin_lvl", pin_lvl, 16'h0);
    chk("R10 pin_evt", pin_evt, 16'h0);
    chk("R10 bus_err", {15'd0, bus_err}, 16'h0);
    chk("R10 bus_rdata", {8'd0, bus_rdata}, 16'h0);
    rd(8'h50, 8'h00, "R10 status");
    rd(8'h7C, 8'h00, "R10 enable");

    // R4 revision
    rd(8'h08, 8'h03, "R4 rev lo");
    rd(8'h09, 8'h00, "R4 rev hi");
    wr(8'h08, 8'h55);
    chk("R4 no err on rev write", {15'd0, bus_err}, 16'h0);
    rd(8'h08, 8'h03, "R4 rev after write");

    // R1 / R2 interrupt lines
    @(negedge clk); sub_irq = 8'h09; tick();
    chk("R2 masked off", {15'd0, host_irq}, 16'h0);
    rd(8'h50, 8'h09, "R1 lines 0,3");
    wr(8'h52, 8'h08);
    chk("R2 mask hit", {15'd0, host_irq}, 16'h1);
    rd(8'h52, 8'h08, "R2 mask readback");
    @(negedge clk); sub_irq = 8'h01; tick();
    chk("R2 line 3 dropped", {15'd0, host_irq}, 16'h0);
    rd(8'h50, 8'h01, "R1 line 3 cleared");
    wr(8'h52, 8'h10);
    @(negedge clk); sub_irq = 8'h11; tick();
    chk("R2 display line", {15'd0, host_irq}, 16'h1);

    // R3 software writes and collision
    wr(8'h50, 8'hFF);
    rd(8'h50, 8'hFF, "R3 status write");
    @(negedge clk);
    sub_irq = 8'h15;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h50; bus_wdata = 8'h00;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
    chk("R3 cleared bit4 drops irq", {15'd0, host_irq}, 16'h0);
    rd(8'h50, 8'h04, "R3 line wins collision");

    // R5 / R6 / R7 output pins
    wr(8'h7C, 8'hFF);
    chk("R7 enable with zero data", pin_evt, 16'h0000);
    chk("R6 level", pin_lvl, 16'h0000);
    wr(8'h78, 8'hA5);
    chk("R6 level A5", pin_lvl, 16'h00A5);
    chk("R7 event A5", pin_evt, 16'h00A5);
    tick();
    chk("R7 event one cycle", pin_evt, 16'h0000);
    chk("R6 level holds", pin_lvl, 16'h00A5);
    wr(8'h79, 8'hFF);
    chk("R7 disabled byte no event", pin_evt, 16'h0000);
    chk("R6 disabled byte", pin_lvl, 16'h00A5);
    wr(8'h7D, 8'h0F);
    chk("R6 enable opens", pin_lvl, 16'h0FA5);
    chk("R7 enable event", pin_evt, 16'h0F00);
    wr(8'h78, 8'h5A);
    chk("R6 data rewrite", pin_lvl, 16'h0F5A);
    chk("R7 flipped pins", pin_evt, 16'h00FF);
    wr(8'h7A, 8'h3C);
    chk("R7 byte2 no event", pin_evt, 16'h0000);
    chk("R6 byte2 outside pins", pin_lvl, 16'h0F5A);
    wr(8'h7E, 8'h77);
    chk("R6 enable byte2 outside pins", pin_lvl, 16'h0F5A);
    rd(8'h7A, 8'h3C, "R5 data byte2");
    rd(8'h79, 8'hFF, "R5 data byte1");
    rd(8'h78, 8'h5A, "R5 data byte0");
    rd(8'h7C, 8'hFF, "R5 enable byte0");
    rd(8'h7D, 8'h0F, "R5 enable byte1");
    rd(8'h7E, 8'h77, "R5 enable byte2");

    // R8 lanes
    wr(8'h60, 8'h34);
    wr(8'h61, 8'h12);
    wr(8'h60, 8'hAB);
    rd(8'h60, 8'hAB, "R8 enable word lo");
    rd(8'h61, 8'h12, "R8 enable word hi kept");
    wr(8'h9C, 8'h11); wr(8'h9D, 8'h22); wr(8'h9E, 8'h33); wr(8'h9F, 8'h44);
    wr(8'h9E, 8'hEE);
    rd(8'h9C, 8'h11, "R8 wide lane0");
    rd(8'h9D, 8'h22, "R8 wide lane1");
    rd(8'h9E, 8'hEE, "R8 wide lane2");
    rd(8'h9F, 8'h44, "R8 wide lane3");
    wr(8'h54, 8'h5C);
    rd(8'h54, 8'h5C, "R8 routing");
    chk("R8 routing inert", {15'd0, host_irq}, 16'h0);

    // R9 unmapped
    rd(8'h51, 8'h00, "R9 unmapped read");
    chk("R9 err on read", {15'd0, bus_err}, 16'h1);
    tick();
    chk("R9 err one cycle", {15'd0, bus_err}, 16'h0);
    wr(8'h7B, 8'hFF);
    chk("R9 err on write", {15'd0, bus_err}, 16'h1);
    chk("R9 no pin event", pin_evt, 16'h0000);
    rd(8'h7A, 8'h3C, "R9 neighbour kept");
    chk("R9 mapped no err", {15'd0, bus_err}, 16'h0);
    rd(8'h58, 8'h00, "R9 unmapped read 58");

    // R11 read data holds across writes
    wr(8'h52, 8'h00);
    tick();
    chk("R11 rdata hold", {8'd0, bus_rdata}, 16'h0000);
    rd(8'h9F, 8'h44, "R11 fresh read");
    wr(8'h9C, 8'h99);
    tick();
    chk("R11 rdata hold after write", {8'd0, bus_rdata}, 16'h0044);

    repeat (3) tick();
    chk("R11 all reads answered", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule